// File: doc/BRIEF.md
# Two-Level Cross-Correlator Array

This block is a square grid of one-bit correlators. On every accepted sample beat it takes one sample from each of eight "X" lanes and eight "Y" lanes. It forms all 64 cross products at once, one for every X lane paired with every Y lane. Each grid cell counts sign agreements in a 4-bit prescaler. Every wraparound of that prescaler adds one to a 16-bit accumulator in the same cell. The accumulators therefore hold agreement counts in units of sixteen.

A four-level mode reuses the same cells at half the sample rate. Each sample then takes two beats: its sign bits arrive first and its magnitude bits on the following beat. When the signs agree, the cell adds a weight of 1, 2 or 4, chosen by how many of the two magnitude bits are set. Nothing in the grid tracks whether samples are valid, and nothing applies fringe rotation: every accepted beat is correlated as it stands.

A one-cycle dump strobe copies all 64 accumulators into a shadow bank and clears the accumulators and prescalers in the same clock. Integration can start again at once while software reads the shadow bank, one word per request. The sample input and both halves of the readout port use valid/ready handshakes:
- The sample input is stalled only during the dump cycle.
- A read request is accepted when the result register is empty, or is being emptied in that cycle.
- A result is held unchanged for as long as the consumer deasserts its ready.

Top module: `xcorr_grid`

## Requirements
- R1: In two-level mode (`mode_four`=0), every beat accepted when `s_valid` and `s_ready` are both high adds one to the prescaler of cell (i,j) exactly when `s_x[i]` equals `s_y[j]`. Each wrap of the 4-bit prescaler increments that cell's 16-bit accumulator, so a dump reports the agreement count divided by 16, with the remainder dropped.
- R2: A read request is accepted in a cycle where `rd_valid` and `rd_ready` are both high. The result appears on `rd_data` with `rd_dvalid` high on the next cycle. `rd_addr[5:3]` selects the X lane i and `rd_addr[2:0]` selects the Y lane j. `rd_ready` is low while a result is waiting and `rd_dready` is low.
- R3: A `dump` cycle copies every accumulator into the shadow bank and clears all accumulators and prescalers. An unfinished prescaler remainder is discarded and never reaches a later dump.
- R4: A cycle with `s_valid` low changes no count, whatever is on `s_x` and `s_y`.
- R5: `s_ready` is low in every cycle where `dump` is high. A beat offered in that cycle is not taken and is not correlated.
- R6: In four-level mode (`mode_four`=1), accepted beats alternate between a sign beat and a magnitude beat. Each magnitude beat adds to cell (i,j) the weight 1 shifted left by (x magnitude bit + y magnitude bit), that is 1, 2 or 4. The add happens only when the two sign bits from the preceding sign beat agree; otherwise the cell adds nothing.
- R7: A dump returns the four-level beat phase to "sign". A lone sign beat before a dump contributes nothing, and the next accepted beat is again treated as a sign beat.
- R8: After reset the shadow bank reads as zero everywhere, `rd_dvalid` is low and `s_ready` is high.
- R9: While `rd_dvalid` is high and `rd_dready` is low, `rd_dvalid` stays high and `rd_data` does not change.
- R10: Reads return the values captured by the most recent dump, unaffected by beats accepted since that dump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_four | input | 1 | 0: two-level beats; 1: four-level sign/magnitude beat pairs |
| dump | input | 1 | Copy accumulators to the shadow bank and clear them |
| s_valid | input | 1 | Sample beat offered |
| s_ready | output | 1 | Sample beat can be taken (low during a dump) |
| s_x | input | 8 | X lane bits (sign or magnitude by phase) |
| s_y | input | 8 | Y lane bits (sign or magnitude by phase) |
| rd_valid | input | 1 | Read request offered |
| rd_ready | output | 1 | Read request can be taken |
| rd_addr | input | 6 | Cell address {X lane, Y lane} |
| rd_dvalid | output | 1 | Read result present |
| rd_dready | input | 1 | Consumer takes the read result |
| rd_data | output | 16 | Shadow word of the addressed cell |

## Verification
The hardest states to reach from the ports are the ones a dump cuts short. One is a prescaler holding 15 agreements when the dump arrives. The other is four-level mode left half-way through a beat pair. To reach the first, the stimulus feeds beats where every X bit equals every Y bit, 15 and then 1 at a time, each run followed by a dump. Reading zero after both runs shows the remainder was discarded. To reach the second, a single sign beat is sent just before a dump, and the weighted pairs that follow must give exactly the model's sums. A scoreboard reads all 64 cells after each dump while the result consumer stalls on a fixed pattern. Some of those reads are made after new beats have been taken, to show that reads see only the last dump.

// File: rtl/xcorr_pkg.sv
package xcorr_pkg;

  // widest per-beat increment of a cell: 1 << 2
  localparam int unsigned STEP_W = 3;

  // Weight of one cell update: agreement of signs, scaled by the count of
  // set magnitude bits (always zero magnitude in two-level mode).
  function automatic logic [STEP_W-1:0] step_weight(input logic agree,
                                                    input logic mag_x,
                                                    input logic mag_y);
    logic [1:0] shamt;
    shamt = {1'b0, mag_x} + {1'b0, mag_y};
    return agree ? (STEP_W'(1) << shamt) : '0;
  endfunction

endpackage

// File: rtl/xc_frontend.sv
module xc_frontend #(
  parameter int unsigned LANES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_four,
  input  logic             dump,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [LANES-1:0] s_x,
  input  logic [LANES-1:0] s_y,
  output logic             step,
  output logic [LANES-1:0] sgn_x,
  output logic [LANES-1:0] sgn_y,
  output logic [LANES-1:0] mag_x,
  output logic [LANES-1:0] mag_y,
  output logic             phase
);

  logic             take;
  logic             phase_q;
  logic [LANES-1:0] hold_x_q;
  logic [LANES-1:0] hold_y_q;

  assign s_ready = !dump;
  assign take    = s_valid && s_ready;
  assign phase   = phase_q;

  // phase_q = 1 means the next accepted beat carries magnitudes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= 1'b0;
      hold_x_q <= '0;
      hold_y_q <= '0;
    end else if (dump || !mode_four) begin
      phase_q <= 1'b0;
    end else if (take) begin
      phase_q <= !phase_q;
      if (!phase_q) begin
        hold_x_q <= s_x;
        hold_y_q <= s_y;
      end
    end
  end

  always_comb begin
    if (mode_four) begin
      step  = take && phase_q;
      sgn_x = hold_x_q;
      sgn_y = hold_y_q;
      mag_x = s_x;
      mag_y = s_y;
    end else begin
      step  = take;
      sgn_x = s_x;
      sgn_y = s_y;
      mag_x = '0;
      mag_y = '0;
    end
  end

endmodule

// File: rtl/xc_cell.sv
module xc_cell #(
  parameter int unsigned PRE_W  = 4,
  parameter int unsigned ACC_W  = 16,
  parameter int unsigned STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  input  logic [STEP_W-1:0] inc,
  output logic [ACC_W-1:0]  acc
);

  localparam int unsigned SUM_W = PRE_W + 1;

  logic [PRE_W-1:0] pre_q;
  logic [ACC_W-1:0] acc_q;
  logic [SUM_W-1:0] sum;

  assign sum = {1'b0, pre_q} + {{(SUM_W-STEP_W){1'b0}}, inc};
  assign acc = acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      acc_q <= '0;
    end else if (clear) begin
      pre_q <= '0;
      acc_q <= '0;
    end else if (step) begin
      pre_q <= sum[PRE_W-1:0];
      acc_q <= acc_q + {{(ACC_W-1){1'b0}}, sum[PRE_W]};
    end
  end

endmodule

// File: rtl/xc_array.sv
module xc_array #(
  parameter int unsigned LANES = 8,
  parameter int unsigned PRE_W = 4,
  parameter int unsigned ACC_W = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clear,
  input  logic                           step,
  input  logic [LANES-1:0]               sgn_x,
  input  logic [LANES-1:0]               sgn_y,
  input  logic [LANES-1:0]               mag_x,
  input  logic [LANES-1:0]               mag_y,
  output logic [LANES*LANES*ACC_W-1:0]   acc_flat
);

  import xcorr_pkg::*;

  for (genvar i = 0; i < LANES; i++) begin : g_x
    for (genvar j = 0; j < LANES; j++) begin : g_y
      localparam int unsigned K = i * LANES + j;
      logic [STEP_W-1:0] inc;

      assign inc = step_weight(sgn_x[i] ~^ sgn_y[j], mag_x[i], mag_y[j]);

      xc_cell #(
        .PRE_W (PRE_W),
        .ACC_W (ACC_W),
        .STEP_W(STEP_W)
      ) u_cell (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(clear),
        .step (step),
        .inc  (inc),
        .acc  (acc_flat[K*ACC_W +: ACC_W])
      );
    end
  end

endmodule

// File: rtl/xc_readout.sv
module xc_readout #(
  parameter int unsigned CELLS = 64,
  parameter int unsigned ACC_W = 16,
  parameter int unsigned AW    = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   dump,
  input  logic [CELLS*ACC_W-1:0] acc_flat,
  input  logic                   rd_valid,
  output logic                   rd_ready,
  input  logic [AW-1:0]          rd_addr,
  output logic                   rd_dvalid,
  input  logic                   rd_dready,
  output logic [ACC_W-1:0]       rd_data
);

  logic [ACC_W-1:0] shadow_q [CELLS];
  logic [ACC_W-1:0] data_q;
  logic             dvalid_q;

  assign rd_ready  = !dvalid_q || rd_dready;
  assign rd_dvalid = dvalid_q;
  assign rd_data   = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < CELLS; k++) shadow_q[k] <= '0;
    end else if (dump) begin
      for (int k = 0; k < CELLS; k++) shadow_q[k] <= acc_flat[k*ACC_W +: ACC_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvalid_q <= 1'b0;
      data_q   <= '0;
    end else if (rd_valid && rd_ready) begin
      dvalid_q <= 1'b1;
      data_q   <= shadow_q[rd_addr];
    end else if (rd_dready) begin
      dvalid_q <= 1'b0;
    end
  end

endmodule

// File: rtl/xcorr_grid.sv
module xcorr_grid #(
  parameter int unsigned LANES = 8,
  parameter int unsigned PRE_W = 4,
  parameter int unsigned ACC_W = 16,
  localparam int unsigned CELLS = LANES * LANES,
  localparam int unsigned AW    = $clog2(CELLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_four,
  input  logic             dump,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [LANES-1:0] s_x,
  input  logic [LANES-1:0] s_y,
  input  logic             rd_valid,
  output logic             rd_ready,
  input  logic [AW-1:0]    rd_addr,
  output logic             rd_dvalid,
  input  logic             rd_dready,
  output logic [ACC_W-1:0] rd_data
);

  logic                   step;
  logic                   fe_phase;
  logic [LANES-1:0]       sgn_x;
  logic [LANES-1:0]       sgn_y;
  logic [LANES-1:0]       mag_x;
  logic [LANES-1:0]       mag_y;
  logic [CELLS*ACC_W-1:0] acc_flat;

  xc_frontend #(.LANES(LANES)) u_fe (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_four(mode_four),
    .dump     (dump),
    .s_valid  (s_valid),
    .s_ready  (s_ready),
    .s_x      (s_x),
    .s_y      (s_y),
    .step     (step),
    .sgn_x    (sgn_x),
    .sgn_y    (sgn_y),
    .mag_x    (mag_x),
    .mag_y    (mag_y),
    .phase    (fe_phase)
  );

  xc_array #(.LANES(LANES), .PRE_W(PRE_W), .ACC_W(ACC_W)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (dump),
    .step    (step),
    .sgn_x   (sgn_x),
    .sgn_y   (sgn_y),
    .mag_x   (mag_x),
    .mag_y   (mag_y),
    .acc_flat(acc_flat)
  );

  xc_readout #(.CELLS(CELLS), .ACC_W(ACC_W), .AW(AW)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .dump     (dump),
    .acc_flat (acc_flat),
    .rd_valid (rd_valid),
    .rd_ready (rd_ready),
    .rd_addr  (rd_addr),
    .rd_dvalid(rd_dvalid),
    .rd_dready(rd_dready),
    .rd_data  (rd_data)
  );

endmodule

// File: rtl/xcorr_grid_chk.sv
module xcorr_grid_chk #(
  parameter int unsigned CELLS = 64,
  parameter int unsigned ACC_W = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   mode_four,
  input logic                   dump,
  input logic                   s_valid,
  input logic                   s_ready,
  input logic                   rd_valid,
  input logic                   rd_ready,
  input logic                   rd_dvalid,
  input logic                   rd_dready,
  input logic [ACC_W-1:0]       rd_data,
  input logic                   phase,
  input logic [CELLS*ACC_W-1:0] acc_flat
);

  // R5
  dump_stalls_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dump |-> !s_ready);

  // R3
  dump_clears_cells_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dump |=> (acc_flat == '0));

  // R4
  idle_keeps_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_valid && !dump) |=> $stable(acc_flat));

  // R2
  read_result_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |=> rd_dvalid);

  // R2
  stall_blocks_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_dvalid && !rd_dready) |-> !rd_ready);

  // R9
  stalled_result_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_dvalid && !rd_dready) |=> (rd_dvalid && $stable(rd_data)));

  // R6
  phase_alternates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_four && s_valid && s_ready) |=> (phase != $past(phase)));

  // R7
  dump_resets_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dump |=> !phase);

endmodule

bind xcorr_grid xcorr_grid_chk #(.CELLS(CELLS), .ACC_W(ACC_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode_four(mode_four),
  .dump     (dump),
  .s_valid  (s_valid),
  .s_ready  (s_ready),
  .rd_valid (rd_valid),
  .rd_ready (rd_ready),
  .rd_dvalid(rd_dvalid),
  .rd_dready(rd_dready),
  .rd_data  (rd_data),
  .phase    (fe_phase),
  .acc_flat (acc_flat)
);

// File: tb/xcorr_grid_bench.sv
module xcorr_grid_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_four = 1'b0;
  logic       dump = 1'b0;
  logic       s_valid = 1'b0;
  logic       s_ready;
  logic [7:0] s_x = '0;
  logic [7:0] s_y = '0;
  logic       rd_valid = 1'b0;
  logic       rd_ready;
  logic [5:0] rd_addr = '0;
  logic       rd_dvalid;
  logic       rd_dready = 1'b1;
  logic [15:0] rd_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  xcorr_grid u_xcorr_grid (
    .clk(clk), .rst_n(rst_n), .mode_four(mode_four), .dump(dump),
    .s_valid(s_valid), .s_ready(s_ready), .s_x(s_x), .s_y(s_y),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_dvalid(rd_dvalid), .rd_dready(rd_dready), .rd_data(rd_data)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // model: weighted agreement total since last dump, and dumped words
  int          total [64];
  logic [15:0] shadow_exp [64];

  logic [15:0] exp_q [$];
  int          addr_q [$];
  string       tag_q [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // two-level beat (also used raw for four-level halves)
  task automatic beat(input logic [7:0] x, input logic [7:0] y);
    @(negedge clk); #1;
    s_valid = 1'b1; s_x = x; s_y = y;
  endtask

  task automatic beat2(input logic [7:0] x, input logic [7:0] y);
    beat(x, y);
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        if (x[i] == y[j]) total[i*8+j] += 1;
  endtask

  task automatic pair4(input logic [7:0] sx, input logic [7:0] mx,
                       input logic [7:0] sy, input logic [7:0] my);
    beat(sx, sy);
    beat(mx, my);
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        if (sx[i] == sy[j]) total[i*8+j] += (1 << (int'(mx[i]) + int'(my[j])));
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #1;
      s_valid = 1'b0; s_x = 8'hA5; s_y = 8'hA5;   // R4: agreeing data, not valid
    end
  endtask

  // R5: a beat is offered during the dump and must be ignored
  task automatic do_dump();
    @(negedge clk); #1;
    dump = 1'b1; s_valid = 1'b1; s_x = 8'hFF; s_y = 8'hFF;
    #1;
    chk(s_ready == 1'b0, "R5", "s_ready during dump", s_ready, 0);
    for (int k = 0; k < 64; k++) begin
      shadow_exp[k] = 16'((total[k] >> 4) & 16'hFFFF);
      total[k] = 0;
    end
    @(negedge clk); #1;
    dump = 1'b0; s_valid = 1'b0;
  endtask

  task automatic read_all(input string tag);
    for (int a = 0; a < 64; a++) begin
      bit done = 0;
      while (!done) begin
        @(negedge clk); #1;
        rd_valid = 1'b1; rd_addr = 6'(a);
        if (rd_ready) begin
          exp_q.push_back(shadow_exp[a]);
          addr_q.push_back(a);
          tag_q.push_back(tag);
          done = 1;
        end
      end
    end
    @(negedge clk); #1;
    rd_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // monitor / result consumer with a fixed stall pattern
  int   mon_cyc = 0;
  bit   prev_stall = 0;
  logic [15:0] held = '0;
  always @(negedge clk) begin
    mon_cyc++;
    if (prev_stall)
      chk(rd_dvalid && (rd_data == held), "R9", "stalled result changed",
          int'(rd_data), int'(held));
    rd_dready = (mon_cyc % 3 != 1);
    prev_stall = rd_dvalid && !rd_dready;
    held = rd_data;
    if (rd_dvalid && rd_dready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2", "unexpected read result", int'(rd_data), -1);
      end else begin
        logic [15:0] e;
        int a;
        string t;
        e = exp_q.pop_front(); a = addr_q.pop_front(); t = tag_q.pop_front();
        chk(rd_data == e, t, $sformatf("cell %0d", a), int'(rd_data), int'(e));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog", "run did not complete", 0, 1);
      finish_run();
    end
  end

  initial begin
    for (int k = 0; k < 64; k++) begin total[k] = 0; shadow_exp[k] = '0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(rd_dvalid == 1'b0, "R8", "rd_dvalid after reset", rd_dvalid, 0);
    chk(s_ready == 1'b1, "R8", "s_ready after reset", s_ready, 1);
    read_all("R8");

    // R1 and R4: two-level beats with invalid gaps
    for (int b = 0; b < 300; b++) begin
      beat2(8'(b * 37 + 5), 8'((b * 91 + 13) ^ (b >> 2)));
      if (b % 50 == 7) idle(3);
    end
    for (int b = 0; b < 40; b++) beat2(8'h0F, 8'h0F);
    idle(2);
    do_dump();
    read_all("R1");

    // R10: new beats after the dump must not show in reads
    for (int b = 0; b < 64; b++) beat2(8'hFF, 8'hFF);
    idle(1);
    read_all("R10");

    // R3: prescaler remainder is dropped at dump
    do_dump();
    for (int b = 0; b < 15; b++) beat2(8'hFF, 8'hFF);
    idle(1);
    do_dump();
    read_all("R3");
    beat2(8'hFF, 8'hFF);
    idle(1);
    do_dump();
    read_all("R3");
    for (int b = 0; b < 16; b++) beat2(8'h3C, 8'hC3);
    idle(1);
    do_dump();
    read_all("R1");

    // R6 and R7: four-level pairs, with a lone sign beat cut by a dump
    mode_four = 1'b1;
    idle(1);
    beat(8'hFF, 8'hFF);
    idle(1);
    do_dump();
    for (int p = 0; p < 200; p++) begin
      pair4(8'(p * 29 + 3), 8'(p * 53 + 11), 8'((p * 17) ^ 8'h5A), 8'(p * 71 + 1));
      if (p % 40 == 9) idle(2);
    end
    for (int p = 0; p < 16; p++) pair4(8'hF0, 8'hFF, 8'hF0, 8'h0F);
    idle(1);
    do_dump();
    read_all("R6");
    beat(8'h00, 8'h00);
    idle(1);
    do_dump();
    for (int p = 0; p < 20; p++) pair4(8'hAA, 8'hFF, 8'hAA, 8'hFF);
    idle(1);
    do_dump();
    read_all("R7");

    finished = 1;
    finish_run();
  end

endmodule